// File: doc/BRIEF.md
# Pipelined Bit-Serial-Order Maximum Selector

This block returns the larger of two unsigned words. The decision is made one bit position at a time, starting at the top bit and working downward. Each position is handled by a one-bit slice. The slice looks at one bit of each operand and at two lead flags from the position above it. One flag says the first operand has already won, the other says the second operand has. The slice passes refreshed flags downward and produces one bit of the result.

Every slice is a separate pipeline stage. A new operand pair can enter on every clock, and its result appears a fixed number of cycles later equal to the word width. Operand words travel down the stages alongside the flags, so each stage finds its bit in step with the flags from above. Each stage adds its result bit to a partial result word that also travels downward, which lines up all result bits of one pair on the same output cycle. A valid bit follows the same path.

Top module: `max_select_pipe`

## Requirements
- R1: After synchronous active-high reset, out_valid is 0 and max_out is all zeros.
- R2: out_valid equals the value in_valid had exactly W clock edges earlier, where W is the operand width (default 4).
- R3: max_out equals the larger of the opa and opb values sampled W clock edges earlier, read as unsigned numbers.
- R4: A new pair is accepted on every clock with no stall, so back-to-back pairs produce back-to-back results in the same order.
- R5: When both operands are equal, max_out equals that common value.
- R6: The highest bit position where the operands differ decides the winner; lower bits of the losing operand never appear in the result (for example 8 against 7 gives 8).
- R7: With in_valid low, the data path still computes; max_out still shows the larger bus value W cycles later while out_valid stays 0.
- R8: A reset applied while pairs are in flight discards them all; on the cycle after the reset edge, out_valid is 0 and max_out is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | W | First unsigned operand |
| opb | input | W | Second unsigned operand |
| in_valid | input | 1 | Marks opa/opb as a pair to process |
| max_out | output | W | Larger of the pair entered W cycles earlier |
| out_valid | output | 1 | Marks max_out as a valid result |

## Verification
The hardest case to reach from the ports is a pair whose winner is settled at a high bit while many different pairs sit in the stages behind and ahead of it, because a wrong skew only shows when neighbouring pairs differ at the bit a stage reads. The bench therefore streams all 256 pairs of the 4-bit configuration back to back, so every stage always holds a different pair. It also places directed pairs whose first difference is at the top bit against complementary low bits, and a reset in the middle of a full pipeline.

// File: rtl/max_select_pipe.sv
module max_select_pipe #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         in_valid,
  output logic [W-1:0] max_out,
  output logic         out_valid
);

  logic [W-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= (vld_q << 1) | W'(in_valid);
  end

  assign out_valid = vld_q[W-1];

  genvar k;
  generate
    for (k = 0; k < W; k++) begin : stg
      localparam int IDX = W - 1 - k;

      logic [W-1:0] a_q, b_q, m_q;
      logic         ga_q, gb_q;

      logic [W-1:0] a_in, b_in, m_in, m_nx;
      logic         ga_in, gb_in;
      logic         ai, bi, mb, ga_nx, gb_nx;

      if (k == 0) begin : g_head
        assign a_in  = opa;
        assign b_in  = opb;
        assign m_in  = '0;
        assign ga_in = 1'b0;
        assign gb_in = 1'b0;
      end else begin : g_body
        assign a_in  = stg[k-1].a_q;
        assign b_in  = stg[k-1].b_q;
        assign m_in  = stg[k-1].m_q;
        assign ga_in = stg[k-1].ga_q;
        assign gb_in = stg[k-1].gb_q;

        p_lead_a_sticky_r6: assert property (@(posedge clk) disable iff (rst)
          stg[k-1].ga_q |=> stg[k].ga_q);
        p_lead_b_sticky_r6: assert property (@(posedge clk) disable iff (rst)
          stg[k-1].gb_q |=> stg[k].gb_q);
      end

      assign ai    = a_in[IDX];
      assign bi    = b_in[IDX];
      assign ga_nx = ga_in | (~gb_in & ai & ~bi);
      assign gb_nx = gb_in | (~ga_in & bi & ~ai);
      assign mb    = ga_in ? ai : (gb_in ? bi : (ai | bi));

      always_comb begin
        m_nx      = m_in;
        m_nx[IDX] = mb;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          a_q  <= '0;
          b_q  <= '0;
          m_q  <= '0;
          ga_q <= 1'b0;
          gb_q <= 1'b0;
        end else begin
          a_q  <= a_in;
          b_q  <= b_in;
          m_q  <= m_nx;
          ga_q <= ga_nx;
          gb_q <= gb_nx;
        end
      end

      p_flags_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(ga_q && gb_q));
    end
  endgenerate

  assign max_out = stg[W-1].m_q;

  p_max_bounds_r3: assert property (@(posedge clk) disable iff (rst)
    (max_out >= stg[W-1].a_q) && (max_out >= stg[W-1].b_q));
  p_max_pick_r3: assert property (@(posedge clk) disable iff (rst)
    (max_out == stg[W-1].a_q) || (max_out == stg[W-1].b_q));

endmodule

// File: tb/max_select_pipe_tb.sv
`timescale 1ns/1ps
module max_select_pipe_tb;
  localparam int W = 4;
  localparam int HN = 4096;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa = '0, opb = '0;
  logic         in_valid = 1'b0;
  logic [W-1:0] max_out;
  logic         out_valid;

  int checks = 0, failures = 0, cyc = 0;
  logic [W-1:0] hm [HN];
  logic         hv [HN];
  string        ht [HN];

  always #4 clk = ~clk;

  max_select_pipe #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .in_valid(in_valid),
    .max_out(max_out), .out_valid(out_valid)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic r, input string tag);
    @(negedge clk);
    if (cyc >= W) begin
      chk(ht[(cyc-W)%HN], W'(out_valid), W'(hv[(cyc-W)%HN]), "out_valid");
      chk(ht[(cyc-W)%HN], max_out, hm[(cyc-W)%HN], "max_out");
    end
    rst = r; in_valid = v; opa = a; opb = b;
    if (r) begin
      hv[cyc%HN] = 1'b0; hm[cyc%HN] = '0; ht[cyc%HN] = tag;
      for (int j = 1; j < W; j++) if (cyc - j >= 0) begin
        hv[(cyc-j)%HN] = 1'b0; hm[(cyc-j)%HN] = '0; ht[(cyc-j)%HN] = tag;
      end
    end else begin
      hv[cyc%HN] = v; hm[cyc%HN] = (a > b) ? a : b; ht[cyc%HN] = tag;
    end
    cyc++;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < W + 1; i++) step(1'b1, 4'd9, 4'd3, 1'b1, "R1");
    @(negedge clk);
    chk("R1", W'(out_valid), '0, "out_valid after reset");
    chk("R1", max_out, '0, "max_out after reset");
    step(1'b0, '0, '0, 1'b0, "R1");

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        step(1'b1, 4'(a), 4'(b), 1'b0, (a == b) ? "R5" : ((a + b) % 2 == 0 ? "R3" : "R4"));

    step(1'b1, 4'd8,  4'd7,  1'b0, "R6");
    step(1'b1, 4'd7,  4'd8,  1'b0, "R6");
    step(1'b1, 4'd4,  4'd3,  1'b0, "R6");
    step(1'b1, 4'd11, 4'd12, 1'b0, "R6");
    step(1'b1, 4'd10, 4'd5,  1'b0, "R6");
    step(1'b1, 4'd15, 4'd15, 1'b0, "R5");
    step(1'b1, 4'd0,  4'd0,  1'b0, "R5");

    for (int i = 0; i < 12; i++)
      step(i % 3 != 0, 4'((i * 5 + 2) % 16), 4'((i * 11 + 7) % 16), 1'b0, "R2");
    for (int i = 0; i < 8; i++)
      step(1'b0, 4'((i * 7 + 1) % 16), 4'((i * 3 + 9) % 16), 1'b0, "R7");

    for (int i = 0; i < W; i++) step(1'b1, 4'(i + 12), 4'(i + 3), 1'b0, "R8");
    step(1'b1, 4'd14, 4'd2, 1'b1, "R8");
    for (int i = 0; i < 3; i++) step(1'b1, 4'(i + 5), 4'(i * 4), 1'b0, "R8");

    for (int i = 0; i < W + 2; i++) step(1'b0, '0, '0, 1'b0, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule